// File: doc/BRIEF.md
# Comma Detect and Byte Aligner

This receive-side block takes a retimed serial stream, one bit per clock, and restores the 10-bit character framing from it. It watches a 10-bit sliding window for the positive-disparity K28.5 comma, whose first seven bits on the line are 0011111. When a comma completes at an offset other than the current character boundary, the block moves the boundary so that the comma sits at bit 0. Bit 0 is the first bit received.

Each framed character leaves the block as two 5-bit groups on a shared bus. A first-group strobe marks bits 0 to 4, and a second-group strobe marks bits 5 to 9. A realignment only ever lengthens the strobe period. The character holding the misaligned comma is dropped and nothing is emitted until the new boundary, so the next comma arrives framed on the first-group strobe. A lock flag reports that two commas in a row were seen at the same alignment.

Top module: `comma_aligner`

## Requirements
- R1: While `rst_n` is low, `grp0_stb`, `grp1_stb`, `grp_data` and `locked` are all 0 after the first clock edge.
- R2: A misaligned comma resets the framing. The first character after that comma, and every character after it, carries the bits in arrival order, with the earliest bit at bit 0.
- R3: A character's bits 0..4 appear on `grp_data` together with a one-cycle `grp0_stb`. Its bits 5..9 follow with a one-cycle `grp1_stb` 5 bit times later, unless a realigning comma completes within the first four bit times after `grp0_stb`. In that case the second group follows 5 bit times after that comma. The two strobes are never high together, and `grp_data` holds between strobes.
- R4: Two `grp0_stb` pulses are never less than 10 bit times apart. After a comma arrives k bit times late (0<k<10), the interval spanning the realignment is 10+k.
- R5: The character completed by a misaligned comma is not emitted.
- R6: With no comma out of place, the first 10 bits after reset form the first character, and one character is emitted every 10 bit times.
- R7: `locked` rises together with the `grp0_stb` of the second comma seen in a row at the same alignment, and stays high while further commas keep that alignment.
- R8: A comma at a different offset clears `locked` in the bit time it completes, with no `grp0_stb` in that cycle. That comma counts as the first at the new alignment.
- R9: A comma is any window whose bits 0..6 are 0,0,1,1,1,1,1. Bits 7..9 are ignored, so 0011111000 also aligns. A window such as 0011110101 never realigns and never touches `locked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Retimed serial bit, one per cycle |
| grp_data | output | GRP_W | Current 5-bit group of the framed character |
| grp0_stb | output | 1 | Strobe for bits 0..4 |
| grp1_stb | output | 1 | Strobe for bits 5..9 |
| locked | output | 1 | Two commas seen at the same alignment |

## Verification
The bench builds the block with its default parameters: 5-bit groups, a 7-bit comma prefix and two hits to lock. With these values a full character is only ten cycles long, so realignment offsets of 3, 5 and 7 bits can each be reached in a few dozen cycles. An offset of 3 lands the comma before the second group of the preceding character is due, and an offset of 7 lands it after. An offset of 5 coincides with that group's due bit time. A near-miss pattern placed off-boundary shows that the lock and the framing survive it.

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int GRP_W = 5,
  parameter int MATCH_W = 7,
  parameter logic [MATCH_W-1:0] COMMA_BITS = 7'b1111100,
  parameter int LOCK_HITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_bit,
  output logic [GRP_W-1:0] grp_data,
  output logic             grp0_stb,
  output logic             grp1_stb,
  output logic             locked
);
  localparam int CHAR_W = 2 * GRP_W;
  localparam int POS_W = $clog2(CHAR_W);
  localparam int HIT_W = $clog2(LOCK_HITS + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CHAR_W - 1);
  localparam logic [POS_W-1:0] POS_MID = POS_W'(GRP_W - 1);
  localparam logic [HIT_W-1:0] HIT_MAX = HIT_W'(LOCK_HITS);

  logic [CHAR_W-1:0] win, win_nx;
  logic [POS_W-1:0]  pos;
  logic [HIT_W-1:0]  hits, hits_nx;
  logic [GRP_W-1:0]  upper;
  logic              upper_due;
  logic              hit, at_end, realign;

  assign win_nx  = {ser_bit, win[CHAR_W-1:1]};
  assign hit     = win_nx[MATCH_W-1:0] == COMMA_BITS;
  assign at_end  = pos == POS_LAST;
  assign realign = hit && !at_end;

  always_comb begin
    hits_nx = hits;
    if (realign) hits_nx = HIT_W'(1);
    else if (hit && hits != HIT_MAX) hits_nx = hits + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win       <= '0;
      pos       <= '0;
      hits      <= '0;
      locked    <= 1'b0;
      upper     <= '0;
      upper_due <= 1'b0;
      grp_data  <= '0;
      grp0_stb  <= 1'b0;
      grp1_stb  <= 1'b0;
    end else begin
      win      <= win_nx;
      pos      <= (at_end || realign) ? '0 : pos + 1'b1;
      hits     <= hits_nx;
      locked   <= hits_nx == HIT_MAX;
      grp0_stb <= at_end;
      grp1_stb <= 1'b0;
      if (at_end) begin
        grp_data  <= win_nx[GRP_W-1:0];
        upper     <= win_nx[CHAR_W-1:GRP_W];
        upper_due <= 1'b1;
      end else if (upper_due && pos == POS_MID) begin
        grp_data  <= upper;
        grp1_stb  <= 1'b1;
        upper_due <= 1'b0;
      end
    end
  end
endmodule

module comma_aligner_chk #(
  parameter int GRP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [GRP_W-1:0] grp_data,
  input logic             grp0_stb,
  input logic             grp1_stb,
  input logic             locked
);
  localparam int CHAR_W = 2 * GRP_W;

  int   gap;
  logic owe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= 0;
      owe <= 1'b0;
    end else begin
      gap <= grp0_stb ? 1 : ((gap < CHAR_W) ? gap + 1 : gap);
      if (grp0_stb) owe <= 1'b1;
      else if (grp1_stb) owe <= 1'b0;
    end
  end

  // R3
  split_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grp0_stb && grp1_stb));
  // R3
  upper_after_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp1_stb |-> owe);
  // R3
  lower_waits_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp0_stb |-> !owe);
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp0_stb && !grp1_stb) |-> $stable(grp_data));
  // R4
  no_sliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp0_stb |-> gap >= CHAR_W);
  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> grp0_stb);
  // R8
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !grp0_stb);
endmodule

bind comma_aligner comma_aligner_chk #(.GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_data(grp_data),
  .grp0_stb(grp0_stb), .grp1_stb(grp1_stb), .locked(locked)
);

// File: tb/comma_aligner_bench.sv
module comma_aligner_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] K_POS = 10'b0101111100;
  localparam logic [9:0] K_ALT = 10'b0001111100;
  localparam logic [9:0] NEAR  = 10'b1010111100;
  localparam logic [9:0] DA    = 10'b1001101010;
  localparam logic [9:0] DB    = 10'b0110010110;
  localparam logic [9:0] PAD   = 10'b1010010101;

  logic clk = 1'b0, rst_n = 1'b0, ser_bit = 1'b0;
  logic [4:0] grp_data;
  logic grp0_stb, grp1_stb, locked;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [4:0] lo_q[$], hi_q[$];
  int lo_t[$], hi_t[$];
  bit lo_l[$];
  logic [9:0] exp_c[$];
  bit exp_l[$];
  int exp_g[$], exp_h[$];

  comma_aligner u_comma_aligner (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .grp_data(grp_data),
    .grp0_stb(grp0_stb), .grp1_stb(grp1_stb), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (grp0_stb) begin lo_q.push_back(grp_data); lo_t.push_back(cyc); lo_l.push_back(locked); end
    if (grp1_stb) begin hi_q.push_back(grp_data); hi_t.push_back(cyc); end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    ser_bit = b;
  endtask

  task automatic send_char(logic [9:0] c);
    for (int i = 0; i < 10; i++) send_bit(c[i]);
  endtask

  task automatic send_fill(int n);
    for (int i = 0; i < n; i++) send_bit(logic'(i % 2));
  endtask

  function automatic logic [9:0] mix(int k, logic [9:0] c);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = (i < k) ? logic'(i % 2) : c[i-k];
    return r;
  endfunction

  function automatic logic [9:0] near_tail();
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = (i < 4) ? NEAR[6+i] : logic'((i - 4) % 2);
    return r;
  endfunction

  task automatic add(logic [9:0] c, bit l, int g, int h);
    exp_c.push_back(c); exp_l.push_back(l); exp_g.push_back(g); exp_h.push_back(h);
  endtask

  task automatic clear_exp();
    exp_c.delete(); exp_l.delete(); exp_g.delete(); exp_h.delete();
  endtask

  task automatic check_run(string rc, string rl, string rg, string rn, int blo, int bhi);
    #1;
    chk({rn, " lower-group count"}, lo_q.size() - blo, exp_c.size());
    chk({rn, " upper-group count"}, hi_q.size() - bhi, exp_c.size());
    for (int j = 0; j < exp_c.size(); j++) begin
      if (blo + j < lo_q.size()) begin
        chk({rc, " bits 0..4"}, lo_q[blo+j], exp_c[j][4:0]);
        chk({rl, " locked"}, lo_l[blo+j], exp_l[j]);
        if (j > 0 && exp_g[j] >= 0)
          chk({rg, " strobe interval"}, lo_t[blo+j] - lo_t[blo+j-1], exp_g[j]);
      end
      if (bhi + j < hi_q.size()) begin
        chk({rc, " bits 5..9"}, hi_q[bhi+j], exp_c[j][9:5]);
        if (blo + j < lo_q.size())
          chk("R3 upper-group delay", hi_t[bhi+j] - lo_t[blo+j], exp_h[j]);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 grp0_stb", grp0_stb, 0);
    chk("R1 grp1_stb", grp1_stb, 0);
    chk("R1 grp_data", grp_data, 0);
    chk("R1 locked", locked, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_aligned();
    int blo = lo_q.size(), bhi = hi_q.size();
    clear_exp();
    send_char(K_POS); send_char(DA); send_char(K_POS); send_char(DB);
    send_char(PAD); send_char(PAD);
    add(K_POS, 0, -1, 5); add(DA, 0, 10, 5); add(K_POS, 1, 10, 5);
    add(DB, 1, 10, 5); add(PAD, 1, 10, 5);
    check_run("R6", "R7", "R6", "R6", blo, bhi);
  endtask

  task automatic t_shift3();
    int blo = lo_q.size(), bhi = hi_q.size();
    clear_exp();
    send_fill(3); send_char(K_POS); send_char(DA); send_char(K_POS);
    send_char(DB); send_char(PAD); send_char(PAD);
    add(PAD, 1, -1, 5); add(mix(3, K_POS), 1, 10, 8); add(DA, 0, 13, 5);
    add(K_POS, 1, 10, 5); add(DB, 1, 10, 5); add(PAD, 1, 10, 5);
    check_run("R2", "R8", "R4", "R5", blo, bhi);
  endtask

  task automatic t_shift7();
    int blo = lo_q.size(), bhi = hi_q.size();
    clear_exp();
    send_fill(7); send_char(K_POS); send_char(DA); send_char(K_POS);
    send_char(PAD); send_char(PAD);
    add(PAD, 1, -1, 5); add(mix(7, K_POS), 1, 10, 5); add(DA, 0, 17, 5);
    add(K_POS, 1, 10, 5); add(PAD, 1, 10, 5);
    check_run("R2", "R8", "R4", "R5", blo, bhi);
  endtask

  task automatic t_near_miss();
    int blo = lo_q.size(), bhi = hi_q.size();
    clear_exp();
    send_fill(4); send_char(NEAR); send_fill(6); send_char(DA);
    send_char(K_POS); send_char(PAD); send_char(PAD);
    add(PAD, 1, -1, 5); add(mix(4, NEAR), 1, 10, 5); add(near_tail(), 1, 10, 5);
    add(DA, 1, 10, 5); add(K_POS, 1, 10, 5); add(PAD, 1, 10, 5);
    check_run("R9", "R9", "R9", "R9", blo, bhi);
  endtask

  task automatic t_alt_tail();
    int blo = lo_q.size(), bhi = hi_q.size();
    clear_exp();
    send_fill(5); send_char(K_ALT); send_char(DA); send_char(K_POS);
    send_char(PAD); send_char(PAD);
    add(PAD, 1, -1, 5); add(mix(5, K_ALT), 1, 10, 5); add(DA, 0, 15, 5);
    add(K_POS, 1, 10, 5); add(PAD, 1, 10, 5);
    check_run("R9", "R8", "R4", "R5", blo, bhi);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_aligned();
    t_shift3();
    t_shift7();
    t_near_miss();
    t_alt_tail();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule